// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block stores received Ethernet frame bytes in memory owned by software. Memory holds a ring of two-word descriptors that starts at `ring_base`. Word 0 of each descriptor gives the address of a 128-byte buffer. Frame bytes arrive one per beat on a byte stream with valid, data, last, error and broadcast qualifiers, and the block applies backpressure through `in_ready`. When a frame starts, the block reads the current descriptor. It then writes bytes into that descriptor's buffer. When the buffer fills or the frame ends, it hands the buffer back to software by writing the descriptor's status word and then setting the ownership bit in word 0. A frame longer than one buffer continues into the next descriptor.

Memory is reached through one request port that performs a read or a write each cycle. Byte writes use byte lanes. Read data returns on the cycle after the request. A descriptor that software has not yet released, because its ownership bit is still set, is never overwritten. In that case the block discards the rest of the frame and pulses `bna`. Receive runs only while `rx_en` is high. Lowering `rx_en` returns the ring position to the base. The address width `AW` must not exceed 32, `ring_base` must be 8-byte aligned and buffer addresses must be 4-byte aligned.

Top module: `rxr_dma_writer`

## Requirements
- R1: Each accepted byte is written to buffer address plus its offset within the buffer. The write is a single byte-lane write: `mem_be` has exactly one bit set, at position addr[1:0], and the byte is replicated on all four lanes of `mem_wdata`.
- R2: A buffer is closed after 128 bytes, or earlier at the frame's last byte. Closing writes the status word to descriptor address +4 and then writes word 0 back with bit 0 (ownership) set, every other bit of word 0 unchanged. A frame that continues fetches the next descriptor.
- R3: When word 0 bit 1 (wrap) is set, the next descriptor is at `ring_base`. Otherwise the next descriptor is at the current address +8.
- R4: Status word bit 14 is set only in the frame's first buffer. Bit 15 is set only in the buffer holding the frame's last byte.
- R5: Status bits 11:0 carry the total frame length in bytes in the end-of-frame descriptor. They are zero in every other descriptor.
- R6: Status bit 31 is set in the end-of-frame descriptor when `in_bcast` was high with the frame's first byte. It is zero in every other descriptor.
- R7: If a fetched word 0 has bit 0 set, `bna` pulses high for exactly one cycle. The rest of the frame is accepted and discarded with no memory write, and the ring position does not move.
- R8: While `rx_en` is low, `in_ready` is high, bytes are discarded and no memory request is made. On return to high, the ring position is `ring_base`.
- R9: A frame whose last byte carries `in_err` leaves its final buffer unclosed, with no status or ownership write. The next frame reuses that same descriptor.
- R10: Word 0 of a descriptor is read once at each frame start and at each buffer boundary of a continuing frame. Its data is taken on the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive enable; low discards bytes and rewinds the ring |
| ring_base | input | AW | Byte address of the first descriptor |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Byte is the frame's last |
| in_err | input | 1 | Frame is bad (meaningful with in_last) |
| in_bcast | input | 1 | Broadcast destination (meaningful with the first byte) |
| in_ready | output | 1 | Block accepts the current byte |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Byte address |
| mem_be | output | 4 | Byte lane enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read |
| bna | output | 1 | One-cycle pulse: no free buffer, frame discarded |

## Verification
Several properties are checked on every cycle. `bna` is never high on two cycles in a row. Every word 0 write sets the ownership bit. Every status word without the end flag carries a zero length and a clear broadcast bit. Every byte write is single-lane and coincides with an accepted stream beat. Descriptor reads are 8-byte aligned, and memory is quiet in the cycle after `rx_en` is low. Only the bench scenarios can show the rest, because each needs a model of the ring: the ordering of status and ownership writes, frames spanning buffers and wrapping to the base, the exact 128-byte boundary, discard on a held descriptor, reuse of a descriptor after an errored frame, and the rewind that lowering `rx_en` causes.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_CHECK,
        ST_DATA,
        ST_WR1,
        ST_WR0,
        ST_DROP
    } rxr_state_e;

    localparam int DESC_STRIDE = 8;
    localparam int OWN_BIT     = 0;
    localparam int WRAP_BIT    = 1;
    localparam int SOF_BIT     = 14;
    localparam int EOF_BIT     = 15;
    localparam int BCAST_BIT   = 31;
    localparam int LEN_FIELD_W = 12;

    typedef struct packed {
        logic                   bcast;
        logic                   eof;
        logic                   sof;
        logic [LEN_FIELD_W-1:0] len;
    } rxr_status_t;

    function automatic logic [31:0] pack_status(input rxr_status_t s);
        logic [31:0] w;
        w = '0;
        w[BCAST_BIT] = s.bcast;
        w[EOF_BIT]   = s.eof;
        w[SOF_BIT]   = s.sof;
        w[LEN_FIELD_W-1:0] = s.len;
        return w;
    endfunction

    function automatic logic [31:0] claim_word(input logic [31:0] w0);
        logic [31:0] w;
        w = w0;
        w[OWN_BIT] = 1'b1;
        return w;
    endfunction

    function automatic logic [3:0] lane_of(input logic [1:0] a);
        return 4'b0001 << a;
    endfunction

endpackage

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rx_en,
    input  logic [AW-1:0] base,
    input  logic          advance,
    input  logic          wrap,
    output logic [AW-1:0] cur
);
    import rxr_pkg::*;

    localparam logic [AW-1:0] STEP = AW'(DESC_STRIDE);

    always_ff @(posedge clk) begin
        if (rst || !rx_en) begin
            cur <= base;
        end else if (advance) begin
            cur <= wrap ? base : cur + STEP;
        end
    end
endmodule

// File: rtl/rxr_frame_ctr.sv
module rxr_frame_ctr #(
    parameter int OFF_W = 7,
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_clr,
    input  logic             buf_clr,
    input  logic             byte_acc,
    output logic [OFF_W-1:0] offset,
    output logic [LEN_W-1:0] length
);
    always_ff @(posedge clk) begin
        if (rst || buf_clr) begin
            offset <= '0;
        end else if (byte_acc) begin
            offset <= offset + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || frame_clr) begin
            length <= '0;
        end else if (byte_acc) begin
            length <= length + 1'b1;
        end
    end
endmodule

// File: rtl/rxr_mem_port.sv
module rxr_mem_port #(
    parameter int AW    = 32,
    parameter int OFF_W = 7
) (
    input  rxr_pkg::rxr_state_e st,
    input  logic [AW-1:0]       desc_addr,
    input  logic [AW-1:0]       buf_base,
    input  logic [OFF_W-1:0]    offset,
    input  logic                byte_go,
    input  logic [7:0]          byte_data,
    input  logic [31:0]         status_word,
    input  logic [31:0]         own_word,
    output logic                req,
    output logic                we,
    output logic [AW-1:0]       addr,
    output logic [3:0]          be,
    output logic [31:0]         wdata
);
    import rxr_pkg::*;

    logic [AW-1:0] byte_addr;
    assign byte_addr = buf_base + AW'(offset);

    always_comb begin
        req   = 1'b0;
        we    = 1'b0;
        addr  = '0;
        be    = 4'b0000;
        wdata = '0;
        case (st)
            ST_FETCH: begin
                req  = 1'b1;
                addr = desc_addr;
            end
            ST_DATA: begin
                if (byte_go) begin
                    req   = 1'b1;
                    we    = 1'b1;
                    addr  = byte_addr;
                    be    = lane_of(byte_addr[1:0]);
                    wdata = {4{byte_data}};
                end
            end
            ST_WR1: begin
                req   = 1'b1;
                we    = 1'b1;
                addr  = desc_addr + AW'(4);
                be    = 4'b1111;
                wdata = status_word;
            end
            ST_WR0: begin
                req   = 1'b1;
                we    = 1'b1;
                addr  = desc_addr;
                be    = 4'b1111;
                wdata = own_word;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/rxr_dma_writer.sv
module rxr_dma_writer #(
    parameter int AW        = 32,
    parameter int BUF_BYTES = 128,
    parameter int LEN_W     = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rx_en,
    input  logic [AW-1:0] ring_base,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    input  logic          in_last,
    input  logic          in_err,
    input  logic          in_bcast,
    output logic          in_ready,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [3:0]    mem_be,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    output logic          bna
);
    import rxr_pkg::*;

    localparam int OFF_W = $clog2(BUF_BYTES);
    localparam logic [OFF_W-1:0] OFF_LAST = OFF_W'(BUF_BYTES - 1);

    rxr_state_e st, st_nxt;
    logic [31:0]      desc_w0;
    logic             sof_pend;
    logic             eof_q;
    logic             bcast_q;
    logic [AW-1:0]    cur_desc;
    logic [OFF_W-1:0] offset;
    logic [LEN_W-1:0] length;
    logic             byte_acc;
    logic             frame_clr;
    logic             buf_clr;
    logic             advance;
    logic             found_busy;
    rxr_status_t      status;
    logic [AW-1:0]    buf_base;

    assign in_ready   = (st == ST_IDLE && !rx_en) ||
                        (rx_en && (st == ST_DATA || st == ST_DROP));
    assign byte_acc   = rx_en && st == ST_DATA && in_valid;
    assign frame_clr  = rx_en && st == ST_IDLE && in_valid;
    assign buf_clr    = st == ST_CHECK;
    assign advance    = st == ST_WR0;
    assign found_busy = mem_rdata[OWN_BIT];
    assign buf_base   = {desc_w0[AW-1:2], 2'b00};

    always_comb begin
        status.bcast = bcast_q && eof_q;
        status.eof   = eof_q;
        status.sof   = sof_pend;
        status.len   = eof_q ? LEN_FIELD_W'(length) : '0;
    end

    always_comb begin
        st_nxt = st;
        if (!rx_en) begin
            st_nxt = ST_IDLE;
        end else begin
            case (st)
                ST_IDLE:  if (in_valid) st_nxt = ST_FETCH;
                ST_FETCH: st_nxt = ST_CHECK;
                ST_CHECK: st_nxt = found_busy ? ST_DROP : ST_DATA;
                ST_DATA: begin
                    if (in_valid) begin
                        if (in_last)
                            st_nxt = in_err ? ST_IDLE : ST_WR1;
                        else if (offset == OFF_LAST)
                            st_nxt = ST_WR1;
                    end
                end
                ST_WR1:   st_nxt = ST_WR0;
                ST_WR0:   st_nxt = eof_q ? ST_IDLE : ST_FETCH;
                ST_DROP:  if (in_valid && in_last) st_nxt = ST_IDLE;
                default:  st_nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            desc_w0  <= '0;
            sof_pend <= 1'b0;
            eof_q    <= 1'b0;
            bcast_q  <= 1'b0;
            bna      <= 1'b0;
        end else begin
            st  <= st_nxt;
            bna <= rx_en && st == ST_CHECK && found_busy;
            if (frame_clr) begin
                sof_pend <= 1'b1;
                bcast_q  <= in_bcast;
                eof_q    <= 1'b0;
            end
            if (rx_en && st == ST_CHECK && !found_busy)
                desc_w0 <= mem_rdata;
            if (byte_acc)
                eof_q <= in_last && !in_err;
            if (advance)
                sof_pend <= 1'b0;
        end
    end

    rxr_ring_ptr #(.AW(AW)) u_ptr (
        .clk     (clk),
        .rst     (rst),
        .rx_en   (rx_en),
        .base    (ring_base),
        .advance (advance),
        .wrap    (desc_w0[WRAP_BIT]),
        .cur     (cur_desc)
    );

    rxr_frame_ctr #(.OFF_W(OFF_W), .LEN_W(LEN_W)) u_ctr (
        .clk       (clk),
        .rst       (rst),
        .frame_clr (frame_clr),
        .buf_clr   (buf_clr),
        .byte_acc  (byte_acc),
        .offset    (offset),
        .length    (length)
    );

    rxr_mem_port #(.AW(AW), .OFF_W(OFF_W)) u_port (
        .st          (st),
        .desc_addr   (cur_desc),
        .buf_base    (buf_base),
        .offset      (offset),
        .byte_go     (byte_acc),
        .byte_data   (in_data),
        .status_word (pack_status(status)),
        .own_word    (claim_word(desc_w0)),
        .req         (mem_req),
        .we          (mem_we),
        .addr        (mem_addr),
        .be          (mem_be),
        .wdata       (mem_wdata)
    );
endmodule

// File: rtl/rxr_dma_writer_chk.sv
module rxr_dma_writer_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          rx_en,
    input logic          in_valid,
    input logic          in_ready,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [3:0]    mem_be,
    input logic [31:0]   mem_wdata,
    input logic          bna
);
    logic own_wr, stat_wr, byte_wr;
    assign own_wr  = mem_req && mem_we && mem_be == 4'hf && !mem_addr[2];
    assign stat_wr = mem_req && mem_we && mem_be == 4'hf &&  mem_addr[2];
    assign byte_wr = mem_req && mem_we && mem_be != 4'hf;

    // R7
    a_r7_bna_single: assert property (@(posedge clk) disable iff (rst)
        bna |=> !bna);
    // R8
    a_r8_off_quiet: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> !mem_req);
    // R2
    a_r2_own_set: assert property (@(posedge clk) disable iff (rst)
        own_wr |-> mem_wdata[0]);
    // R5 and R6
    a_r5_len_zero: assert property (@(posedge clk) disable iff (rst)
        (stat_wr && !mem_wdata[15]) |-> (mem_wdata[11:0] == 12'd0 && !mem_wdata[31]));
    // R1
    a_r1_single_lane: assert property (@(posedge clk) disable iff (rst)
        byte_wr |-> ($countones(mem_be) == 1 && in_valid && in_ready));
    // R10
    a_r10_read_align: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |-> mem_addr[2:0] == 3'd0);
endmodule

bind rxr_dma_writer rxr_dma_writer_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rx_en     (rx_en),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_be    (mem_be),
    .mem_wdata (mem_wdata),
    .bna       (bna)
);

// File: tb/tb_rxr_dma_writer.sv
`timescale 1ns/1ps
module tb_rxr_dma_writer;
    localparam int AW = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_en = 1'b0;
    logic [AW-1:0] ring_base = 32'h0;
    logic in_valid = 1'b0, in_last = 1'b0, in_err = 1'b0, in_bcast = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic in_ready, mem_req, mem_we, bna;
    logic [AW-1:0] mem_addr;
    logic [3:0] mem_be;
    logic [31:0] mem_wdata, mem_rdata;

    logic [31:0] mem [256];

    int n_chk = 0, n_fail = 0;
    int bna_seen = 0, bna_exp = 0;
    int ring_idx = 0;
    logic sw_used [4];
    logic [63:0] exp_desc [$];
    logic [39:0] exp_byte [$];
    logic [31:0] exp_rd [$];

    always #2 clk = ~clk;

    rxr_dma_writer dut (
        .clk(clk), .rst(rst), .rx_en(rx_en), .ring_base(ring_base),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .in_err(in_err), .in_bcast(in_bcast), .in_ready(in_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .bna(bna)
    );

    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) begin
                for (int b = 0; b < 4; b++)
                    if (mem_be[b]) mem[mem_addr[9:2]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
            end else begin
                mem_rdata <= mem[mem_addr[9:2]];
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] buf_of(input int i);
        return 32'h100 + 32'(i) * 32'd128;
    endfunction

    function automatic logic [31:0] w0_of(input int i);
        return buf_of(i) | ((i == 3) ? 32'h2 : 32'h0);
    endfunction

    // scoreboard monitor
    always @(negedge clk) begin
        #1;
        if (!rst) begin
            if (bna) bna_seen++;
            if (mem_req && !mem_we) begin
                if (exp_rd.size() == 0) check(0, "R10 unexpected read", {32'h0, mem_addr}, 64'h0);
                else begin
                    logic [31:0] e;
                    e = exp_rd.pop_front();
                    check(mem_addr == e, "R10/R3 descriptor read address", {32'h0, mem_addr}, {32'h0, e});
                end
            end else if (mem_req && mem_we && mem_be == 4'hf) begin
                if (exp_desc.size() == 0) check(0, "R2/R7/R9 unexpected descriptor write", {mem_addr, mem_wdata}, 64'h0);
                else begin
                    logic [63:0] e;
                    e = exp_desc.pop_front();
                    check({mem_addr, mem_wdata} == e, "R2/R4/R5/R6 descriptor write", {mem_addr, mem_wdata}, e);
                end
            end else if (mem_req && mem_we) begin
                if (exp_byte.size() == 0) check(0, "R1/R7/R8 unexpected byte write", {mem_addr, mem_wdata}, 64'h0);
                else begin
                    logic [39:0] e;
                    logic [7:0] got;
                    e = exp_byte.pop_front();
                    got = mem_wdata[mem_addr[1:0]*8 +: 8];
                    check(mem_addr == e[39:8] && mem_be == (4'b1 << mem_addr[1:0]) && got == e[7:0],
                          "R1 byte write", {mem_addr, 28'h0, mem_be, got}, {e[39:8], 28'h0, 4'b1 << e[9:8], e[7:0]});
                end
            end
        end
    end

    task automatic free_desc(input int i);
        @(negedge clk);
        mem[i*2] = w0_of(i);
        mem[i*2+1] = 32'h0;
        sw_used[i] = 1'b0;
    endtask

    task automatic send_frame(input int n, input bit bc, input bit er, input int seed);
        int k;
        bit first;
        // expectations from the ring model
        if (rx_en) begin
            k = 0;
            first = 1;
            forever begin
                int chunk;
                bit last;
                logic [31:0] w1;
                exp_rd.push_back(32'(ring_idx) * 32'd8);
                if (sw_used[ring_idx]) begin
                    bna_exp++;
                    break;
                end
                chunk = (n - k > 128) ? 128 : n - k;
                for (int j = 0; j < chunk; j++)
                    exp_byte.push_back({buf_of(ring_idx) + 32'(j), 8'(seed + k + j)});
                k += chunk;
                last = (k == n);
                if (last && er) break;
                w1 = ((last && bc) ? 32'h8000_0000 : 32'h0) | (last ? 32'h8000 : 32'h0) |
                     (first ? 32'h4000 : 32'h0) | (last ? 32'(n) : 32'h0);
                exp_desc.push_back({32'(ring_idx) * 32'd8 + 32'd4, w1});
                exp_desc.push_back({32'(ring_idx) * 32'd8, w0_of(ring_idx) | 32'h1});
                sw_used[ring_idx] = 1'b1;
                ring_idx = (ring_idx == 3) ? 0 : ring_idx + 1;
                first = 0;
                if (last) break;
            end
        end
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = 8'(seed + i);
            in_last  = (i == n - 1);
            in_err   = er && (i == n - 1);
            in_bcast = bc;
            #1;
            while (!in_ready) @(negedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        in_err   = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    task automatic check_drained(input string req);
        check(exp_desc.size() == 0 && exp_byte.size() == 0 && exp_rd.size() == 0, req,
              64'(exp_desc.size() + exp_byte.size() + exp_rd.size()), 64'h0);
        check(bna_seen == bna_exp, {req, " R7 bna count"}, 64'(bna_seen), 64'(bna_exp));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        for (int i = 0; i < 4; i++) begin
            mem[i*2] = w0_of(i);
            sw_used[i] = 1'b0;
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #1;
        // reset state, receive disabled (R8)
        check(!mem_req && !bna, "R8 reset quiet", {62'h0, mem_req, bna}, 64'h0);
        check(in_ready, "R8 ready while disabled", 64'(in_ready), 64'h1);
        @(negedge clk);
        rx_en = 1'b1;
        repeat (2) @(negedge clk);

        send_frame(60, 1, 0, 8'h10);          // R6 broadcast, single buffer
        check_drained("R4/R5/R6 short frame");
        send_frame(200, 0, 0, 8'h40);         // R2 spans two buffers
        check_drained("R2/R4/R5 two-buffer frame");
        send_frame(128, 0, 0, 8'h80);         // exact buffer, wrap descriptor R3
        check_drained("R3/R5 exact 128 with wrap");
        send_frame(10, 0, 0, 8'hC0);          // desc0 still owned: R7
        check_drained("R7 held descriptor");

        free_desc(0);
        free_desc(1);
        send_frame(20, 0, 1, 8'h20);          // R9 errored frame
        check_drained("R9 errored frame");
        send_frame(5, 0, 0, 8'h30);           // R9 reuses desc0
        check_drained("R9 descriptor reuse");

        @(negedge clk);
        rx_en = 1'b0;                         // R8 rewind and discard
        send_frame(3, 0, 0, 8'h55);
        check_drained("R8 discard while disabled");
        ring_idx = 0;
        free_desc(0);
        @(negedge clk);
        rx_en = 1'b1;
        repeat (2) @(negedge clk);
        send_frame(4, 1, 0, 8'h60);
        check_drained("R8 rewind to base");

        send_frame(150, 0, 0, 8'h70);         // R7 mid-frame held descriptor
        check_drained("R7 mid-frame discard");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule